// File: doc/BRIEF.md
# Glitch-Free Clock Gating Control

This block switches one clock network on and off from an enable request that may arrive at any time, with no relation to the clock. The request travels through a short chain of registers clocked on the falling edge of the clock being gated. The last enable in the chain is ANDed with the clock. Because the enable can only change while the clock is low, the gated output never carries a clipped or runt high phase.

Each stage of the chain can be bypassed by a static select input. The select is captured while reset is held and frozen afterwards, so it behaves as configuration rather than as a run-time control. Using the second stage adds a metastability guard for asynchronous requests, at the cost of one more falling edge of latency. Bypassing both stages leaves a purely combinational path. A build parameter marks instances that drive a clock out of the chip. On those instances every stage is always used, whatever the select bits hold.

Top module: `clkgate_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears every enable register, so `clk_gated` is low for as long as `rst_n` is low. This holds even when `en_req` is high and at least one stage is in use.
- R2: `clk_gated` equals `clk_in` AND the final enable. A rising edge of `clk_gated` only happens together with a rising edge of `clk_in`. While `clk_in` is low, `clk_gated` is low.
- R3: Each enable register captures its input on the falling edge of `clk_in`. With `byp_sel` = 2'b00 (both stages used), a level of `en_req` present at a falling edge reaches `clk_gated` after the second falling edge from that one.
- R4: With `byp_sel` = 2'b10 (bit 1 set, so the second stage is bypassed), a level of `en_req` sampled at a falling edge reaches `clk_gated` right after that same falling edge.
- R5: With `byp_sel` = 2'b01 (bit 0 set, so the first stage is bypassed), the second stage samples `en_req` directly. The latency is again one falling edge.
- R6: With `byp_sel` = 2'b11, both stages are bypassed and `clk_gated` follows `clk_in` AND `en_req` combinationally.
- R7: When the parameter `EXT_PIN` = 1, `byp_sel` is ignored and the latency is always two falling edges, as in R3.
- R8: `byp_sel` is sampled on rising edges of `clk_in` while `rst_n` is low and then held. A change of `byp_sel` after reset has no effect on the latency.
- R9: While at least one stage is in use, every high pulse on `clk_gated` lasts exactly one full high phase of `clk_in`, even for enable toggles at random phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be gated |
| rst_n | input | 1 | Active-low asynchronous reset; select capture window |
| en_req | input | 1 | Enable request, may be asynchronous |
| byp_sel | input | STAGES | Static stage bypass selects; bit i bypasses stage i |
| clk_gated | output | 1 | Gated clock output |

## Verification
Each of the four bypass settings is tried in turn. Every setting gets a directed enable pulse placed just after a falling edge and then several hundred enable toggles, each placed at a random phase in either the high or the low half of the clock. The directed pulse separates a one-edge latency from a two-edge latency. The random toggles that land while the clock is high separate a registered path from a combinational one, and they show up any clipped pulse through its measured width. A second instance built for an external pin runs alongside with a conflicting select, which exposes any bypass that leaks through. Flipping `byp_sel` after each reset shows whether the captured setting is truly held.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  localparam int MAX_STAGES = 8;

  // Number of enable stages that are actually registered
  function automatic int unsigned count_used(input logic [MAX_STAGES-1:0] byp,
                                             input int unsigned n);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (!byp[i]) cnt++;
    end
    return cnt;
  endfunction

  // Bypass vector after applying the external-pin restriction
  function automatic logic [MAX_STAGES-1:0] allowed_bypass(input logic ext_pin,
                                                           input logic [MAX_STAGES-1:0] sel);
    return ext_pin ? '0 : sel;
  endfunction

endpackage

// File: rtl/clkgate_cfg_hold.sv
module clkgate_cfg_hold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sel_in,
  output logic [W-1:0] sel_q
);

  // Loads only during reset; frozen once reset is released
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= sel_in;
  end

endmodule

// File: rtl/clkgate_fall_stage.sv
module clkgate_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic byp,
  output logic r,
  output logic q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) r <= 1'b0;
    else        r <= d;
  end

  assign q = byp ? d : r;

endmodule

// File: rtl/clkgate_and.sv
module clkgate_and (
  input  logic clk_in,
  input  logic en,
  output logic clk_out
);

  assign clk_out = clk_in & en;

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int STAGES  = 2,
  parameter bit EXT_PIN = 1'b0
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic [STAGES-1:0] byp_sel,
  output logic              clk_gated
);

  localparam int CW = 8;

  logic [STAGES-1:0] cfg_q;
  logic [STAGES-1:0] eff_byp;
  logic [STAGES-1:0] stage_reg;
  logic [STAGES-1:0] stage_d;
  logic [STAGES:0]   chain;
  logic              en_final;
  logic [CW-1:0]     used_cnt;

  clkgate_cfg_hold #(.W(STAGES)) u_cfg (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .sel_in (byp_sel),
    .sel_q  (cfg_q)
  );

  assign eff_byp  = STAGES'(allowed_bypass(EXT_PIN, MAX_STAGES'(cfg_q)));
  assign used_cnt = CW'(count_used(MAX_STAGES'(eff_byp), STAGES));

  assign chain[0] = en_req;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      clkgate_fall_stage u_st (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d     (chain[g]),
        .byp   (eff_byp[g]),
        .r     (stage_reg[g]),
        .q     (chain[g+1])
      );
      assign stage_d[g] = chain[g];
    end
  endgenerate

  assign en_final = chain[STAGES];

  clkgate_and u_and (
    .clk_in  (clk_in),
    .en      (en_final),
    .clk_out (clk_gated)
  );

endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int STAGES  = 2,
  parameter bit EXT_PIN = 1'b0
) (
  input logic              clk_in,
  input logic              rst_n,
  input logic              clk_gated,
  input logic              en_final,
  input logic [STAGES-1:0] stage_reg,
  input logic [STAGES-1:0] stage_d,
  input logic [STAGES-1:0] cfg_q,
  input logic [7:0]        used_cnt
);

  always @(posedge clk_in) begin
    if (!rst_n) AST_RESET_CLEAR: assert (stage_reg == '0); // R1
  end

  always @(posedge clk_gated) begin
    if (rst_n) AST_RISE_WITH_CLK: assert (clk_in); // R2
  end

  always @(negedge clk_gated) begin
    if (rst_n && used_cnt != 8'd0) AST_NO_RUNT: assert (!clk_in); // R9
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_cap
      AST_STAGE_CAPTURE: assert property (@(negedge clk_in) disable iff (!rst_n)
        rst_n |=> stage_reg[i] == $past(stage_d[i])); // R3
    end
    if (EXT_PIN) begin : g_ext
      AST_EXT_FULL_DEPTH: assert property (@(posedge clk_in) disable iff (!rst_n)
        en_final == stage_reg[STAGES-1]); // R7
    end
  endgenerate

  AST_CFG_HELD: assert property (@(posedge clk_in) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q)); // R8

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.STAGES(STAGES), .EXT_PIN(EXT_PIN)) u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .clk_gated (clk_gated),
  .en_final  (en_final),
  .stage_reg (stage_reg),
  .stage_d   (stage_d),
  .cfg_q     (cfg_q),
  .used_cnt  (used_cnt)
);

// File: tb/clkgate_ctrl_tb.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_req = 1'b0;
  logic [1:0] byp_sel = 2'b00;
  logic       clk_gated, clk_gated_ext;

  int    checks = 0;
  int    errors = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  int    n_main = 2;
  string tag_main = "R3";
  bit    hist[$];
  realtime t_rise_m = 0.0, t_rise_e = 0.0;

  always #4 clk = ~clk; // 125 MHz

  clkgate_ctrl #(.STAGES(2), .EXT_PIN(1'b0)) u_dut (
    .clk_in(clk), .rst_n(rst_n), .en_req(en_req), .byp_sel(byp_sel), .clk_gated(clk_gated));

  clkgate_ctrl #(.STAGES(2), .EXT_PIN(1'b1)) u_dut_ext (
    .clk_in(clk), .rst_n(rst_n), .en_req(en_req), .byp_sel(2'b11), .clk_gated(clk_gated_ext));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: history of en_req sampled at falling edges, newest first
  always @(negedge clk) begin
    if (!rst_n) hist = '{1'b0, 1'b0, 1'b0, 1'b0};
    else begin
      hist.push_front(en_req);
      void'(hist.pop_back());
    end
  end

  function automatic bit exp_en(input int n);
    if (n == 0) return en_req;
    return hist[n-1];
  endfunction

  // Mid-high comparison: latency per setting (R3 R4 R5 R6), external pin (R7)
  always @(posedge clk) begin
    #2;
    if (chk_on && rst_n) begin
      chk(clk_gated, exp_en(n_main), tag_main);
      chk(clk_gated_ext, hist[1], "R7");
    end
  end

  // Mid-low: gated output low while the clock is low (R2)
  always @(negedge clk) begin
    #2;
    if (chk_on && rst_n) begin
      if (n_main > 0) chk(clk_gated, 1'b0, "R2");
      chk(clk_gated_ext, 1'b0, "R2");
    end
  end

  // Pulse edges and widths (R2, R9)
  always @(posedge clk_gated) begin
    t_rise_m = $realtime;
    if (chk_on && rst_n) chk(clk, 1'b1, "R2");
  end
  always @(negedge clk_gated) begin
    if (chk_on && rst_n && n_main > 0)
      chk_int(int'(($realtime - t_rise_m) * 1000.0), 4000, "R9");
  end
  always @(posedge clk_gated_ext) t_rise_e = $realtime;
  always @(negedge clk_gated_ext) begin
    if (chk_on && rst_n)
      chk_int(int'(($realtime - t_rise_e) * 1000.0), 4000, "R9");
  end

  task automatic do_reset(input logic [1:0] sel);
    chk_on = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b0;
    byp_sel = sel;
    en_req = 1'b1;
    repeat (3) begin
      @(posedge clk); #2;
      if (sel != 2'b11) chk(clk_gated, 1'b0, "R1");
      chk(clk_gated_ext, 1'b0, "R1");
    end
    @(negedge clk); #1;
    en_req = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    byp_sel = ~sel; // must be ignored (R8)
  endtask

  task automatic run_phase(input logic [1:0] sel, input int n, input string tag, input int ncyc);
    do_reset(sel);
    n_main = n;
    tag_main = tag;
    chk_on = 1'b1;
    @(negedge clk); #1;
    en_req = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    en_req = 1'b0;
    repeat (4) @(posedge clk);
    for (int k = 0; k < ncyc; k++) begin
      if ($urandom % 2 == 0) @(posedge clk);
      else @(negedge clk);
      #(0.35 + 0.1 * ($urandom % 36));
      en_req = 1'($urandom % 2);
    end
    @(negedge clk); #1;
    en_req = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    run_phase(2'b00, 2, "R3 R8", 400);
    run_phase(2'b10, 1, "R4 R8", 400);
    run_phase(2'b01, 1, "R5 R8", 400);
    run_phase(2'b11, 0, "R6 R8", 400);
    run_phase(2'b00, 2, "R3 R8", 200);
    chk_on = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule